// File: doc/BRIEF.md
# Pin Interrupt Edge and Level Detector

This block is a bank of pin interrupt channels (eight by default). Each channel watches one input bit that has already been synchronised to the block clock. Each channel produces its own interrupt request. A channel runs in one of two sensing styles, chosen by its mode bit.

In edge style, the channel latches rising and falling transitions into sticky flags and raises a pending status. Software acknowledges the pending status by writing ones to a clear port. In level style, the status tracks the pin directly against a chosen polarity, and acknowledge writes do nothing.

Two enable vectors control each channel. Each vector is reached only through separate set and clear strobe ports, so one field can change without a read-modify-write. The first vector turns on rising-edge sensing, or in level style turns on the level request. The second vector has two meanings. In edge style it turns on falling-edge sensing. In level style it selects the active polarity.

Top module: `pint_bank`

## Requirements
- R1: `mode_o[i]` = 0 means edge style and 1 means level style. The whole vector is loaded from `mode_wdata_i` when `mode_we_i` is high. On that load, every channel whose mode bit changes has its rise flag, fall flag and status cleared in the same cycle.
- R2: `rise_en_o` changes only through `rise_en_set_i` and `rise_en_clr_i`. A 1 in a strobe bit sets or clears that bit one cycle later, and a 0 leaves it alone. When set and clear hit the same bit together, set wins.
- R3: `fall_en_o` uses `fall_en_set_i` and `fall_en_clr_i` with exactly the same set, clear and set-wins rules as R2.
- R4: Edge detection compares the pin sample of the current cycle with the sample of the previous cycle. For an edge-style channel with its rise enable at 1, a 0-to-1 change sets `rise_flag_o[i]` and `stat_o[i]` on the following clock edge.
- R5: For an edge-style channel with its fall enable at 1, a 1-to-0 change sets `fall_flag_o[i]` and `stat_o[i]`. With both enables at 1, either direction raises the status.
- R6: A 1 in `rise_flag_clr_i` clears that channel's rise flag, and a 1 in `fall_flag_clr_i` clears its fall flag. The two clears are independent of each other and of the status. If a new edge and a clear land in the same cycle, the flag ends up set.
- R7: Writing 1s to `stat_clr_i` clears the pending status of every edge-style channel in the mask in the same cycle. A pending status that is not cleared stays set. If a new edge and a clear land in the same cycle, the status ends up set.
- R8: A level-style channel has `stat_o[i]` = rise enable AND (pin == fall enable), registered one cycle after the sample. So fall enable 1 means active-high and 0 means active-low. `stat_clr_i` has no effect on it, and its rise and fall flags stay 0.
- R9: `irq_o[i]` is high exactly when `stat_o[i]` is high.
- R10: Reset (`rst_n` low) clears the mode, both enable vectors, both flag vectors, the status and the edge history (the pin history resets to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Synchronised pin levels |
| mode_we_i | input | 1 | Load strobe for the mode vector |
| mode_wdata_i | input | NCH | New mode vector (1 = level style) |
| rise_en_set_i | input | NCH | Set strobes for the rise/level enable |
| rise_en_clr_i | input | NCH | Clear strobes for the rise/level enable |
| fall_en_set_i | input | NCH | Set strobes for the fall/polarity enable |
| fall_en_clr_i | input | NCH | Clear strobes for the fall/polarity enable |
| rise_flag_clr_i | input | NCH | Write-one-to-clear for the rise flags |
| fall_flag_clr_i | input | NCH | Write-one-to-clear for the fall flags |
| stat_clr_i | input | NCH | Write-one-to-clear for the edge pending status |
| mode_o | output | NCH | Current mode vector |
| rise_en_o | output | NCH | Rise/level enable vector |
| fall_en_o | output | NCH | Fall/polarity enable vector |
| rise_flag_o | output | NCH | Sticky rising-edge flags |
| fall_flag_o | output | NCH | Sticky falling-edge flags |
| stat_o | output | NCH | Interrupt status |
| irq_o | output | NCH | Per-channel interrupt request |

## Verification
The bench aims at collisions between events in the same cycle, which is where errors in this block would show up:
- **Edge and clear together.** A design that lets the clear win would lose an edge, and the flag or status would read 0 one cycle later.
- **Set and clear strobes on the same bit.** Getting the priority wrong leaves an enable at 0 where 1 was expected.
- **Level style.** A design that honours acknowledge writes here, or that reads the second enable with the wrong polarity, would drop or invert the request.
- **Mode switch.** A design that keeps stale state across the switch would carry an old pending edge into level style as a false request.

Random pin activity and random strobes are then checked every cycle against a reference model built from the requirements.

// File: rtl/pint_pkg.sv
package pint_pkg;

   typedef enum logic {
      SENSE_EDGE  = 1'b0,
      SENSE_LEVEL = 1'b1
   } sense_e;

   localparam int unsigned PINT_MAX_CH = 32;

endpackage

// File: rtl/pint_en_reg.sv
module pint_en_reg #(
   parameter int unsigned W        = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] nxt;

   // generate picks which strobe has priority on a collision
   if (SET_WINS) begin : g_set_wins
      assign nxt = (q_o & ~clr_i) | set_i;
   end else begin : g_clr_wins
      assign nxt = (q_o | set_i) & ~clr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt;
   end

endmodule

// File: rtl/pint_channel.sv
module pint_channel
   import pint_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic mode_i,
   input  logic mode_chg_i,
   input  logic en_a_i,
   input  logic en_b_i,
   input  logic rflag_clr_i,
   input  logic fflag_clr_i,
   input  logic stat_clr_i,
   output logic rflag_o,
   output logic fflag_o,
   output logic stat_o
);

   sense_e sense;
   logic   prev_q;
   logic   rose, fell, rset, fset;
   logic   lvl_hit, edge_stat;
   logic   rflag_d, fflag_d, stat_d;

   assign sense = sense_e'(mode_i);
   assign rose  = pin_i & ~prev_q;
   assign fell  = ~pin_i & prev_q;
   assign rset  = (sense == SENSE_EDGE) & en_a_i & rose;
   assign fset  = (sense == SENSE_EDGE) & en_b_i & fell;

   // level style: en_b picks polarity, en_a gates the request
   assign lvl_hit   = en_a_i & ~(pin_i ^ en_b_i);
   assign edge_stat = (stat_o & ~stat_clr_i) | rset | fset;

   always_comb begin
      rflag_d = ((rflag_o & ~rflag_clr_i) | rset) & ~mode_chg_i;
      fflag_d = ((fflag_o & ~fflag_clr_i) | fset) & ~mode_chg_i;
      stat_d  = (sense == SENSE_LEVEL) ? lvl_hit : edge_stat;
      if (mode_chg_i) stat_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         rflag_o <= 1'b0;
         fflag_o <= 1'b0;
         stat_o  <= 1'b0;
      end else begin
         prev_q  <= pin_i;
         rflag_o <= rflag_d;
         fflag_o <= fflag_d;
         stat_o  <= stat_d;
      end
   end

endmodule

// File: rtl/pint_bank.sv
module pint_bank
   import pint_pkg::*;
#(
   parameter int unsigned NCH      = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] pin_i,
   input  logic           mode_we_i,
   input  logic [NCH-1:0] mode_wdata_i,
   input  logic [NCH-1:0] rise_en_set_i,
   input  logic [NCH-1:0] rise_en_clr_i,
   input  logic [NCH-1:0] fall_en_set_i,
   input  logic [NCH-1:0] fall_en_clr_i,
   input  logic [NCH-1:0] rise_flag_clr_i,
   input  logic [NCH-1:0] fall_flag_clr_i,
   input  logic [NCH-1:0] stat_clr_i,
   output logic [NCH-1:0] mode_o,
   output logic [NCH-1:0] rise_en_o,
   output logic [NCH-1:0] fall_en_o,
   output logic [NCH-1:0] rise_flag_o,
   output logic [NCH-1:0] fall_flag_o,
   output logic [NCH-1:0] stat_o,
   output logic [NCH-1:0] irq_o
);

   if (NCH < 1 || NCH > PINT_MAX_CH) begin : g_bad_nch
      $error("pint_bank: NCH out of range");
   end

   logic [NCH-1:0] mode_chg;

   assign mode_chg = mode_we_i ? (mode_wdata_i ^ mode_o) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_o <= '0;
      else if (mode_we_i) mode_o <= mode_wdata_i;
   end

   pint_en_reg #(.W(NCH), .SET_WINS(SET_WINS)) u_en_a (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (rise_en_set_i),
      .clr_i (rise_en_clr_i),
      .q_o   (rise_en_o)
   );

   pint_en_reg #(.W(NCH), .SET_WINS(SET_WINS)) u_en_b (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fall_en_set_i),
      .clr_i (fall_en_clr_i),
      .q_o   (fall_en_o)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pint_channel u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_i       (pin_i[i]),
         .mode_i      (mode_o[i]),
         .mode_chg_i  (mode_chg[i]),
         .en_a_i      (rise_en_o[i]),
         .en_b_i      (fall_en_o[i]),
         .rflag_clr_i (rise_flag_clr_i[i]),
         .fflag_clr_i (fall_flag_clr_i[i]),
         .stat_clr_i  (stat_clr_i[i]),
         .rflag_o     (rise_flag_o[i]),
         .fflag_o     (fall_flag_o[i]),
         .stat_o      (stat_o[i])
      );
   end

   assign irq_o = stat_o;

endmodule

// File: rtl/pint_bank_chk.sv
module pint_bank_chk #(
   parameter int unsigned NCH      = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] pin_i,
   input logic           mode_we_i,
   input logic [NCH-1:0] rise_en_set_i,
   input logic [NCH-1:0] rise_en_clr_i,
   input logic [NCH-1:0] fall_en_set_i,
   input logic [NCH-1:0] fall_en_clr_i,
   input logic [NCH-1:0] stat_clr_i,
   input logic [NCH-1:0] mode_o,
   input logic [NCH-1:0] rise_en_o,
   input logic [NCH-1:0] fall_en_o,
   input logic [NCH-1:0] rise_flag_o,
   input logic [NCH-1:0] fall_flag_o,
   input logic [NCH-1:0] stat_o
);

   // R2: a set strobe always lands; a lone clear always lands
   p_rise_en_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((rise_en_o & $past(rise_en_set_i)) == $past(rise_en_set_i)) &&
                ((rise_en_o & $past(rise_en_clr_i & ~rise_en_set_i)) == '0)));

   // R3: same rules for the second enable
   p_fall_en_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((fall_en_o & $past(fall_en_set_i)) == $past(fall_en_set_i)) &&
                ((fall_en_o & $past(fall_en_clr_i & ~fall_en_set_i)) == '0)));

   // R7: an edge-style pending bit not cleared stays pending
   p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_we_i |=> ((~mode_o & $past(stat_o & ~stat_clr_i) & ~stat_o) == '0));

   // R8: level status follows pin against polarity, one cycle later
   p_level_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_we_i |=> ((stat_o & mode_o) ==
                      $past(rise_en_o & ~(pin_i ^ fall_en_o) & mode_o)));

   // R8: level channels never hold edge flags
   p_level_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_flag_o | fall_flag_o) & mode_o) == '0);

endmodule

bind pint_bank pint_bank_chk #(.NCH(NCH), .SET_WINS(SET_WINS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pin_i         (pin_i),
   .mode_we_i     (mode_we_i),
   .rise_en_set_i (rise_en_set_i),
   .rise_en_clr_i (rise_en_clr_i),
   .fall_en_set_i (fall_en_set_i),
   .fall_en_clr_i (fall_en_clr_i),
   .stat_clr_i    (stat_clr_i),
   .mode_o        (mode_o),
   .rise_en_o     (rise_en_o),
   .fall_en_o     (fall_en_o),
   .rise_flag_o   (rise_flag_o),
   .fall_flag_o   (fall_flag_o),
   .stat_o        (stat_o)
);

// File: tb/sim_pint_bank.sv
`timescale 1ns/1ps
module sim_pint_bank;

   localparam int NCH = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] pin_i = '0;
   logic           mode_we_i = 1'b0;
   logic [NCH-1:0] mode_wdata_i = '0;
   logic [NCH-1:0] rise_en_set_i = '0, rise_en_clr_i = '0;
   logic [NCH-1:0] fall_en_set_i = '0, fall_en_clr_i = '0;
   logic [NCH-1:0] rise_flag_clr_i = '0, fall_flag_clr_i = '0, stat_clr_i = '0;
   logic [NCH-1:0] mode_o, rise_en_o, fall_en_o, rise_flag_o, fall_flag_o, stat_o, irq_o;

   // reference model state
   logic [NCH-1:0] m_mode = '0, m_ren = '0, m_fen = '0;
   logic [NCH-1:0] m_rf = '0, m_ff = '0, m_st = '0, m_prev = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pint_bank #(.NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
      .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
      .rise_en_set_i(rise_en_set_i), .rise_en_clr_i(rise_en_clr_i),
      .fall_en_set_i(fall_en_set_i), .fall_en_clr_i(fall_en_clr_i),
      .rise_flag_clr_i(rise_flag_clr_i), .fall_flag_clr_i(fall_flag_clr_i),
      .stat_clr_i(stat_clr_i),
      .mode_o(mode_o), .rise_en_o(rise_en_o), .fall_en_o(fall_en_o),
      .rise_flag_o(rise_flag_o), .fall_flag_o(fall_flag_o),
      .stat_o(stat_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // next model state from the requirements, using inputs held this cycle
   function automatic void model_step();
      logic [NCH-1:0] chg, rise, fall, rset, fset, st_e, st_l;
      chg  = mode_we_i ? (mode_wdata_i ^ m_mode) : '0;
      rise = pin_i & ~m_prev;
      fall = ~pin_i & m_prev;
      rset = ~m_mode & m_ren & rise;
      fset = ~m_mode & m_fen & fall;
      st_e = (m_st & ~stat_clr_i) | rset | fset;
      st_l = m_ren & ~(pin_i ^ m_fen);
      m_rf   = ((m_rf & ~rise_flag_clr_i) | rset) & ~chg;
      m_ff   = ((m_ff & ~fall_flag_clr_i) | fset) & ~chg;
      m_st   = ((m_mode & st_l) | (~m_mode & st_e)) & ~chg;
      m_ren  = (m_ren & ~rise_en_clr_i) | rise_en_set_i;
      m_fen  = (m_fen & ~fall_en_clr_i) | fall_en_set_i;
      m_prev = pin_i;
      if (mode_we_i) m_mode = mode_wdata_i;
   endfunction

   task automatic compare_all();
      chk("R1 mode_o",      32'(mode_o),      32'(m_mode));
      chk("R2 rise_en_o",   32'(rise_en_o),   32'(m_ren));
      chk("R3 fall_en_o",   32'(fall_en_o),   32'(m_fen));
      chk("R4 rise_flag_o", 32'(rise_flag_o), 32'(m_rf));
      chk("R5 fall_flag_o", 32'(fall_flag_o), 32'(m_ff));
      chk("R7 stat_o",      32'(stat_o),      32'(m_st));
      chk("R9 irq_o",       32'(irq_o),       32'(m_st));
   endtask

   // inputs already driven at a falling edge; advance one clock
   task automatic cyc();
      model_step();
      @(negedge clk);
      compare_all();
      mode_we_i = 1'b0; mode_wdata_i = '0;
      rise_en_set_i = '0; rise_en_clr_i = '0;
      fall_en_set_i = '0; fall_en_clr_i = '0;
      rise_flag_clr_i = '0; fall_flag_clr_i = '0; stat_clr_i = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset mode",  32'(mode_o), 0);
      chk("R10 reset enables", 32'(rise_en_o | fall_en_o), 0);
      chk("R10 reset flags", 32'(rise_flag_o | fall_flag_o | stat_o | irq_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 set-wins collision
      rise_en_set_i = 8'h05; cyc();
      rise_en_set_i = 8'h02; rise_en_clr_i = 8'h06; cyc();
      chk("R2 set wins over clear", 32'(rise_en_o), 32'h03);
      // R3
      fall_en_set_i = 8'h03; cyc();
      chk("R3 fall enable set", 32'(fall_en_o), 32'h03);
      // R4 rising edge on ch0
      pin_i[0] = 1'b1; cyc();
      chk("R4 rise flag", 32'(rise_flag_o[0]), 1);
      chk("R4 status",    32'(stat_o[0]), 1);
      // R6 clear rise flag only
      rise_flag_clr_i = 8'h01; cyc();
      chk("R6 rise flag cleared", 32'(rise_flag_o[0]), 0);
      chk("R6 status untouched",  32'(stat_o[0]), 1);
      // R5 falling edge, both edges enabled
      pin_i[0] = 1'b0; cyc();
      chk("R5 fall flag", 32'(fall_flag_o[0]), 1);
      // R7 acknowledge
      stat_clr_i = 8'h01; cyc();
      chk("R7 status cleared", 32'(stat_o[0]), 0);
      // R6/R7 edge wins over same-cycle clear
      pin_i[1] = 1'b1; rise_flag_clr_i = 8'h02; stat_clr_i = 8'h02; cyc();
      chk("R6 edge wins flag",  32'(rise_flag_o[1]), 1);
      chk("R7 edge wins stat",  32'(stat_o[1]), 1);
      // R7 multi-channel mask
      pin_i[0] = 1'b1; cyc();
      stat_clr_i = 8'h03; cyc();
      chk("R7 mask clears both", 32'(stat_o & 8'h03), 0);
      // R1/R8 switch ch0 to level style, active high, pin high
      mode_we_i = 1'b1; mode_wdata_i = 8'h01; cyc();
      chk("R1 mode switch clears", 32'(stat_o[0] | rise_flag_o[0] | fall_flag_o[0]), 0);
      cyc();
      chk("R8 active high", 32'(stat_o[0]), 1);
      stat_clr_i = 8'h01; cyc();
      chk("R8 clear ignored", 32'(stat_o[0]), 1);
      fall_en_clr_i = 8'h01; cyc();
      chk("R8 old polarity still used", 32'(stat_o[0]), 1);
      cyc();
      chk("R8 active low pin high", 32'(stat_o[0]), 0);
      pin_i[0] = 1'b0; cyc();
      chk("R8 active low pin low", 32'(stat_o[0]), 1);
      chk("R9 irq follows", 32'(irq_o[0]), 1);
      pin_i[0] = 1'b1; cyc();
      chk("R8 no flags in level", 32'(rise_flag_o[0] | fall_flag_o[0] | stat_o[0]), 0);
      mode_we_i = 1'b1; mode_wdata_i = 8'h00; cyc();

      // constrained random phase
      for (int k = 0; k < 3000; k++) begin
         if ($urandom_range(0, 3) == 0) pin_i = pin_i ^ NCH'($urandom);
         if ($urandom_range(0, 40) == 0) begin
            mode_we_i = 1'b1; mode_wdata_i = NCH'($urandom);
         end
         if ($urandom_range(0, 5) == 0) rise_en_set_i = NCH'($urandom);
         if ($urandom_range(0, 5) == 0) rise_en_clr_i = NCH'($urandom);
         if ($urandom_range(0, 5) == 0) fall_en_set_i = NCH'($urandom);
         if ($urandom_range(0, 5) == 0) fall_en_clr_i = NCH'($urandom);
         if ($urandom_range(0, 4) == 0) rise_flag_clr_i = NCH'($urandom);
         if ($urandom_range(0, 4) == 0) fall_flag_clr_i = NCH'($urandom);
         if ($urandom_range(0, 3) == 0) stat_clr_i = NCH'($urandom);
         cyc();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule